// File: doc/BRIEF.md
# Shared Memory Bus Arbiter

This block decides whether the host processor or the coprocessor drives a shared program ROM bus and a shared work RAM bus. An 8-bit mode register, written by the host, holds one ownership bit per bus. The owner of a bus has its read and write requests passed straight to the memory, and the memory's read data passed back, in the same cycle.

The two sides are treated differently when they lose. A coprocessor access to a bus it does not own raises a wait signal and reaches no memory. The wait clears by itself as soon as the host hands the bus over. The host never stalls. A host ROM read on a bus it does not own returns a fixed filler byte chosen by the low address nibble. The filler values are picked so that interrupt vectors fetched from ROM point into host-local memory. A host RAM read on a bus it does not own returns the last byte seen on the host data bus (open bus). A host write to a RAM it does not own is discarded.

Memories are modelled as combinational-read devices. Cache and host-only memories do not pass through this block.

Top module: `shared_bus_arbiter`

## Requirements
- R1: The mode register is 8 bits wide and is written by the host whenever `cfg_we` is high. Bit 4 selects the ROM owner and bit 3 selects the RAM owner, with 0 meaning host and 1 meaning coprocessor. Synchronous reset clears the register, so the host owns both buses, and the `*_own_cop` outputs reflect the two bits. The other bits are stored but have no effect.
- R2: A register write captured at a clock edge changes ownership from that edge onward. An access presented in the same cycle as the write is still arbitrated under the old owner.
- R3: A host ROM read while the coprocessor owns ROM returns a filler byte chosen by address bits 3:0. Nibbles 0, 2, 6, 8 and C give 0x00. Nibble 4 gives 0x04, nibble A gives 0x08 and nibble E gives 0x0C. All other nibbles give 0x01.
- R4: A host RAM read while the coprocessor owns RAM returns the open-bus byte. This byte is the last value on the host data bus. In priority order, the bus takes the data of a host ROM read, else the data of a host RAM read, else the data of a host RAM write (dropped or not). It resets to 0x00.
- R5: A host RAM write while the coprocessor owns RAM never reaches the memory, so the stored byte is unchanged.
- R6: A coprocessor ROM read, RAM read or RAM write on a bus it does not own raises `c_wait` in the same cycle. The coprocessor's address then does not reach that memory, which keeps the host's request.
- R7: A waiting coprocessor resumes without any retry. In the first cycle after ownership is granted, `c_wait` is low and the memory data is returned.
- R8: The owner of a bus has its read, write, address and write data routed to the memory, and receives the memory's read data, in the same cycle.
- R9: A coprocessor RAM write issued while the host owns RAM is discarded.
- R10: The two buses are arbitrated independently. The coprocessor may own ROM while the host owns RAM, and each side is served on the bus it owns in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host write strobe for the mode register |
| cfg_wdata | input | 8 | Mode register write data |
| h_rom_rd | input | 1 | Host ROM read request |
| h_rom_addr | input | ROM_AW | Host ROM address |
| h_rom_rdata | output | 8 | Host ROM read data (or filler byte) |
| h_ram_rd | input | 1 | Host RAM read request |
| h_ram_wr | input | 1 | Host RAM write request |
| h_ram_addr | input | RAM_AW | Host RAM address |
| h_ram_wdata | input | 8 | Host RAM write data |
| h_ram_rdata | output | 8 | Host RAM read data (or open-bus byte) |
| c_rom_rd | input | 1 | Coprocessor ROM read request |
| c_rom_addr | input | ROM_AW | Coprocessor ROM address |
| c_rom_rdata | output | 8 | Coprocessor ROM read data |
| c_ram_rd | input | 1 | Coprocessor RAM read request |
| c_ram_wr | input | 1 | Coprocessor RAM write request |
| c_ram_addr | input | RAM_AW | Coprocessor RAM address |
| c_ram_wdata | input | 8 | Coprocessor RAM write data |
| c_ram_rdata | output | 8 | Coprocessor RAM read data |
| c_wait | output | 1 | Coprocessor wait state |
| rom_rd | output | 1 | ROM device read strobe |
| rom_addr | output | ROM_AW | ROM device address |
| rom_rdata | input | 8 | ROM device read data |
| ram_rd | output | 1 | RAM device read strobe |
| ram_wr | output | 1 | RAM device write strobe |
| ram_addr | output | RAM_AW | RAM device address |
| ram_wdata | output | 8 | RAM device write data |
| ram_rdata | input | 8 | RAM device read data |
| rom_own_cop | output | 1 | ROM currently owned by the coprocessor |
| ram_own_cop | output | 1 | RAM currently owned by the coprocessor |

## Verification
Several rules are checked on every cycle by the assertions:
- ownership follows the previous cycle's register write and holds otherwise;
- a stalled coprocessor never drives a memory address;
- dropped writes never raise the RAM write strobe;
- a denied host ROM read only ever yields one of the five filler codes;
- the open-bus byte follows a preceding host write.

Some behaviours only the bench's scenarios can show. These are the exact filler byte for each of the sixteen nibbles, and that a dropped write leaves the stored byte intact once ownership returns. They also include the resume-without-retry sequence and the same-cycle use of the old owner when a write and an access coincide. The bench covers these with directed cases and a long run of random traffic checked against a reference model.

// File: rtl/sba_pkg.sv
// Shared types and the filler-byte rule for the shared bus arbiter.
// Assumes byte-wide data on both shared buses.
package sba_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef enum logic { OWN_HOST = 1'b0, OWN_COP = 1'b1 } owner_e;

    // Filler byte returned to the host for a ROM read it is not allowed to make.
    function automatic byte_t rom_fill_byte(input logic [3:0] nib);
        byte_t v;
        unique case (nib)
            4'h0, 4'h2, 4'h6, 4'h8, 4'hC: v = 8'h00;
            4'h4:                          v = 8'h04;
            4'hA:                          v = 8'h08;
            4'hE:                          v = 8'h0C;
            default:                       v = 8'h01;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/sba_mode_reg.sv
// Host-written 8-bit mode register holding one ownership bit per shared bus.
// Assumes the writer is the host; new owners apply from the capturing edge on.
module sba_mode_reg
    import sba_pkg::*;
#(
    parameter int ROM_BIT = 4,
    parameter int RAM_BIT = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cfg_we,
    input  byte_t  cfg_wdata,
    output owner_e rom_owner,
    output owner_e ram_owner
);
    byte_t mode_q;

    // Capture the host's write; reset hands both buses to the host.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= '0;
        else if (cfg_we) mode_q <= cfg_wdata;
    end

    assign rom_owner = owner_e'(mode_q[ROM_BIT]);
    assign ram_owner = owner_e'(mode_q[RAM_BIT]);

    // R2: ownership follows the previous cycle's write
    p_owner_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we)) |->
        (rom_owner == owner_e'($past(cfg_wdata[ROM_BIT])) &&
         ram_owner == owner_e'($past(cfg_wdata[RAM_BIT]))));

    // R1: without a write both owners hold their value
    p_owner_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we)) |-> ($stable(rom_owner) && $stable(ram_owner)));
endmodule

// File: rtl/sba_rom_path.sv
// ROM bus steering: routes the owner's read to the ROM device.
// Stalls a coprocessor that does not own the bus.
// Gives a denied host read a filler byte. Assumes a combinational-read ROM.
module sba_rom_path
    import sba_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  owner_e        owner,
    input  logic          host_rd,
    input  logic [AW-1:0] host_addr,
    output byte_t         host_rdata,
    input  logic          cop_rd,
    input  logic [AW-1:0] cop_addr,
    output byte_t         cop_rdata,
    output logic          cop_stall,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  byte_t         mem_rdata
);
    logic cop_owns;
    assign cop_owns = (owner == OWN_COP);

    // Steer the device request to whichever side owns the bus.
    always_comb begin
        mem_rd   = cop_owns ? cop_rd   : host_rd;
        mem_addr = cop_owns ? cop_addr : host_addr;
    end

    // Return data to each side: real data for the owner, substitutes otherwise.
    always_comb begin
        host_rdata = cop_owns ? rom_fill_byte(host_addr[3:0]) : mem_rdata;
        cop_rdata  = cop_owns ? mem_rdata : '0;
        cop_stall  = cop_rd && !cop_owns;
    end

    // R3: a denied host read only sees one of the filler codes
    p_fill_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && cop_owns) |->
        (host_rdata inside {8'h00, 8'h01, 8'h04, 8'h08, 8'h0C}));

    // R6: a stalled coprocessor never drives the ROM address
    p_stall_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cop_stall |-> (mem_addr == host_addr && mem_rd == host_rd));

    // R8: the owning coprocessor receives device data
    p_owner_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_owns && cop_rd) |-> (cop_rdata == mem_rdata && !cop_stall));
endmodule

// File: rtl/sba_ram_path.sv
// RAM bus steering: routes the owner's read or write to the RAM device.
// Stalls a coprocessor that does not own the bus.
// Drops the host's writes when denied and answers denied host reads with open-bus data.
module sba_ram_path
    import sba_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  owner_e        owner,
    input  byte_t         open_bus,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  byte_t         host_wdata,
    output byte_t         host_rdata,
    input  logic          cop_rd,
    input  logic          cop_wr,
    input  logic [AW-1:0] cop_addr,
    input  byte_t         cop_wdata,
    output byte_t         cop_rdata,
    output logic          cop_stall,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output byte_t         mem_wdata,
    input  byte_t         mem_rdata
);
    logic cop_owns;
    assign cop_owns = (owner == OWN_COP);

    // Steer the device request; the losing side's strobes are discarded.
    always_comb begin
        mem_rd    = cop_owns ? cop_rd    : host_rd;
        mem_wr    = cop_owns ? cop_wr    : host_wr;
        mem_addr  = cop_owns ? cop_addr  : host_addr;
        mem_wdata = cop_owns ? cop_wdata : host_wdata;
    end

    // Return data to each side and raise the coprocessor wait when denied.
    always_comb begin
        host_rdata = cop_owns ? open_bus : mem_rdata;
        cop_rdata  = cop_owns ? mem_rdata : '0;
        cop_stall  = (cop_rd || cop_wr) && !cop_owns;
    end

    // R5: a host write on a coprocessor-owned RAM never strobes the device
    p_host_write_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_owns && host_wr && !cop_wr) |-> !mem_wr);

    // R9: a stalled coprocessor write never strobes the device
    p_cop_write_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_stall && cop_wr && !host_wr) |-> !mem_wr);

    // R6: a stalled coprocessor never drives the RAM address
    p_stall_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cop_stall |-> (mem_addr == host_addr));
endmodule

// File: rtl/sba_open_bus.sv
// Holds the last byte seen on the host data bus, used as open-bus read data.
// Assumes at most one host data transfer is meaningful per cycle (priority below).
module sba_open_bus
    import sba_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rom_rd,
    input  byte_t rom_data,
    input  logic  ram_rd,
    input  byte_t ram_data,
    input  logic  ram_wr,
    input  byte_t ram_wdata,
    output byte_t bus_q
);
    // Latch the host bus value with ROM read, RAM read, RAM write priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_q <= '0;
        else if (rom_rd) bus_q <= rom_data;
        else if (ram_rd) bus_q <= ram_data;
        else if (ram_wr) bus_q <= ram_wdata;
    end

    // R4: a lone host write leaves its data on the bus
    p_write_sets_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ram_wr) && !$past(rom_rd) && !$past(ram_rd)) |->
        (bus_q == $past(ram_wdata)));

    // R4: an idle host bus keeps its value
    p_idle_bus_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rom_rd) && !$past(ram_rd) && !$past(ram_wr)) |->
        $stable(bus_q));
endmodule

// File: rtl/shared_bus_arbiter.sv
// Top of the shared bus arbiter: mode register, ROM and RAM steering, open-bus latch.
// Assumes combinational-read memories; cache and host-only memories are not routed here.
module shared_bus_arbiter
    import sba_pkg::*;
#(
    parameter int ROM_AW  = 21,
    parameter int RAM_AW  = 17,
    parameter int ROM_BIT = 4,
    parameter int RAM_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              h_rom_rd,
    input  logic [ROM_AW-1:0] h_rom_addr,
    output logic [7:0]        h_rom_rdata,
    input  logic              h_ram_rd,
    input  logic              h_ram_wr,
    input  logic [RAM_AW-1:0] h_ram_addr,
    input  logic [7:0]        h_ram_wdata,
    output logic [7:0]        h_ram_rdata,
    input  logic              c_rom_rd,
    input  logic [ROM_AW-1:0] c_rom_addr,
    output logic [7:0]        c_rom_rdata,
    input  logic              c_ram_rd,
    input  logic              c_ram_wr,
    input  logic [RAM_AW-1:0] c_ram_addr,
    input  logic [7:0]        c_ram_wdata,
    output logic [7:0]        c_ram_rdata,
    output logic              c_wait,
    output logic              rom_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_rdata,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              rom_own_cop,
    output logic              ram_own_cop
);
    owner_e rom_owner, ram_owner;
    byte_t  bus_q;
    logic   rom_stall, ram_stall;

    sba_mode_reg #(.ROM_BIT(ROM_BIT), .RAM_BIT(RAM_BIT)) u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rom_owner(rom_owner), .ram_owner(ram_owner)
    );

    sba_rom_path #(.AW(ROM_AW)) u_rom (
        .clk(clk), .rst_n(rst_n), .owner(rom_owner),
        .host_rd(h_rom_rd), .host_addr(h_rom_addr), .host_rdata(h_rom_rdata),
        .cop_rd(c_rom_rd), .cop_addr(c_rom_addr), .cop_rdata(c_rom_rdata),
        .cop_stall(rom_stall),
        .mem_rd(rom_rd), .mem_addr(rom_addr), .mem_rdata(rom_rdata)
    );

    sba_ram_path #(.AW(RAM_AW)) u_ram (
        .clk(clk), .rst_n(rst_n), .owner(ram_owner), .open_bus(bus_q),
        .host_rd(h_ram_rd), .host_wr(h_ram_wr), .host_addr(h_ram_addr),
        .host_wdata(h_ram_wdata), .host_rdata(h_ram_rdata),
        .cop_rd(c_ram_rd), .cop_wr(c_ram_wr), .cop_addr(c_ram_addr),
        .cop_wdata(c_ram_wdata), .cop_rdata(c_ram_rdata), .cop_stall(ram_stall),
        .mem_rd(ram_rd), .mem_wr(ram_wr), .mem_addr(ram_addr),
        .mem_wdata(ram_wdata), .mem_rdata(ram_rdata)
    );

    sba_open_bus u_bus (
        .clk(clk), .rst_n(rst_n),
        .rom_rd(h_rom_rd), .rom_data(h_rom_rdata),
        .ram_rd(h_ram_rd), .ram_data(h_ram_rdata),
        .ram_wr(h_ram_wr), .ram_wdata(h_ram_wdata),
        .bus_q(bus_q)
    );

    // Combine per-bus stalls into the single coprocessor wait and expose owners.
    always_comb begin
        c_wait      = rom_stall || ram_stall;
        rom_own_cop = (rom_owner == OWN_COP);
        ram_own_cop = (ram_owner == OWN_COP);
    end

    // R6: the wait is only raised while the coprocessor requests something
    p_wait_needs_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_wait |-> (c_rom_rd || c_ram_rd || c_ram_wr));

    // R10: host keeps real RAM data while the coprocessor holds only ROM
    p_independent_buses_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_own_cop && !ram_own_cop && h_ram_rd) |-> (h_ram_rdata == ram_rdata));

    // R7: a granted coprocessor read on ROM alone is never waiting
    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_own_cop && c_rom_rd && !c_ram_rd && !c_ram_wr) |-> !c_wait);
endmodule

// File: tb/shared_bus_arbiter_bench.sv
`timescale 1ns/100ps
module shared_bus_arbiter_bench;
    localparam int ROM_AW = 21;
    localparam int RAM_AW = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic h_rom_rd = 1'b0, h_ram_rd = 1'b0, h_ram_wr = 1'b0;
    logic [ROM_AW-1:0] h_rom_addr = '0, c_rom_addr = '0;
    logic [RAM_AW-1:0] h_ram_addr = '0, c_ram_addr = '0;
    logic [7:0] h_ram_wdata = '0, c_ram_wdata = '0;
    logic c_rom_rd = 1'b0, c_ram_rd = 1'b0, c_ram_wr = 1'b0;
    logic [7:0] h_rom_rdata, h_ram_rdata, c_rom_rdata, c_ram_rdata;
    logic c_wait, rom_rd, ram_rd, ram_wr, rom_own_cop, ram_own_cop;
    logic [ROM_AW-1:0] rom_addr;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0] ram_wdata, rom_rdata, ram_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    shared_bus_arbiter u_shared_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .h_rom_rd(h_rom_rd), .h_rom_addr(h_rom_addr), .h_rom_rdata(h_rom_rdata),
        .h_ram_rd(h_ram_rd), .h_ram_wr(h_ram_wr), .h_ram_addr(h_ram_addr),
        .h_ram_wdata(h_ram_wdata), .h_ram_rdata(h_ram_rdata),
        .c_rom_rd(c_rom_rd), .c_rom_addr(c_rom_addr), .c_rom_rdata(c_rom_rdata),
        .c_ram_rd(c_ram_rd), .c_ram_wr(c_ram_wr), .c_ram_addr(c_ram_addr),
        .c_ram_wdata(c_ram_wdata), .c_ram_rdata(c_ram_rdata), .c_wait(c_wait),
        .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .rom_own_cop(rom_own_cop), .ram_own_cop(ram_own_cop)
    );

    // Memory devices: ROM content is a function of the address, RAM is a small array.
    function automatic logic [7:0] rom_fn(input logic [ROM_AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
    endfunction

    logic [7:0] dev_ram [256];
    assign rom_rdata = rom_fn(rom_addr);
    assign ram_rdata = dev_ram[ram_addr[7:0]];
    always @(posedge clk) if (ram_wr) dev_ram[ram_addr[7:0]] <= ram_wdata;

    // Reference model state.
    logic m_rom_own = 1'b0, m_ram_own = 1'b0;
    logic [7:0] m_bus = 8'h00;
    logic [7:0] m_ram [256];
    logic [7:0] e_h_rom, e_h_ram;

    function automatic logic [7:0] exp_fill(input logic [3:0] n);
        if (n == 4'h4) return 8'h04;
        if (n == 4'hA) return 8'h08;
        if (n == 4'hE) return 8'h0C;
        if (n == 4'h0 || n == 4'h2 || n == 4'h6 || n == 4'h8 || n == 4'hC) return 8'h00;
        return 8'h01;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 0; h_rom_rd = 0; h_ram_rd = 0; h_ram_wr = 0;
        c_rom_rd = 0; c_ram_rd = 0; c_ram_wr = 0;
    endtask

    // Wait past the input change and compare every output against the model.
    task automatic settle();
        logic e_wait;
        #1;
        e_h_rom = m_rom_own ? exp_fill(h_rom_addr[3:0]) : rom_fn(h_rom_addr);
        e_h_ram = m_ram_own ? m_bus : m_ram[h_ram_addr[7:0]];
        e_wait  = (c_rom_rd && !m_rom_own) || ((c_ram_rd || c_ram_wr) && !m_ram_own);
        chk("R2 rom owner", rom_own_cop, m_rom_own);
        chk("R2 ram owner", ram_own_cop, m_ram_own);
        chk("R6 wait", c_wait, e_wait);
        if (h_rom_rd) chk(m_rom_own ? "R3 host rom fill" : "R8 host rom", h_rom_rdata, e_h_rom);
        if (h_ram_rd) chk(m_ram_own ? "R4 host ram open bus" : "R8 host ram", h_ram_rdata, e_h_ram);
        if (c_rom_rd && m_rom_own) chk("R8 cop rom", c_rom_rdata, rom_fn(c_rom_addr));
        if (c_ram_rd && m_ram_own) chk("R8 cop ram", c_ram_rdata, m_ram[c_ram_addr[7:0]]);
        if (!m_rom_own) chk("R6 rom addr host", rom_addr, h_rom_addr);
    endtask

    // Take the clock edge and advance the model by the same rules.
    task automatic advance();
        @(posedge clk);
        if (m_ram_own && c_ram_wr)       m_ram[c_ram_addr[7:0]] = c_ram_wdata;
        else if (!m_ram_own && h_ram_wr) m_ram[h_ram_addr[7:0]] = h_ram_wdata;
        if (h_rom_rd)      m_bus = e_h_rom;
        else if (h_ram_rd) m_bus = e_h_ram;
        else if (h_ram_wr) m_bus = h_ram_wdata;
        if (cfg_we) begin
            m_rom_own = cfg_wdata[4];
            m_ram_own = cfg_wdata[3];
        end
        @(negedge clk);
    endtask

    task automatic cycle();
        settle();
        advance();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            dev_ram[i] = 8'h00;
            m_ram[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state, host owns both buses
        c_rom_rd = 1;
        #1;
        chk("R1 reset rom owner", rom_own_cop, 0);
        chk("R1 reset ram owner", ram_own_cop, 0);
        chk("R1 reset wait", c_wait, 1);
        @(negedge clk);
        rst_n = 1;
        idle();
        @(negedge clk);

        // R1: bits other than 3 and 4 have no effect
        cfg_we = 1; cfg_wdata = 8'hE7; cycle(); idle();
        c_rom_rd = 1; c_rom_addr = 21'h123; c_ram_rd = 1; c_ram_addr = 17'h5;
        settle();
        chk("R1 other bits ignored", c_wait, 1);
        advance(); idle();

        // R2: write and host access in the same cycle use the old owner
        cfg_we = 1; cfg_wdata = 8'h10; h_rom_rd = 1; h_rom_addr = 21'h0_4444;
        settle();
        chk("R2 same cycle old owner", h_rom_rdata, rom_fn(21'h0_4444));
        advance(); idle();
        h_rom_rd = 1; h_rom_addr = 21'h0_4444;
        settle();
        chk("R2 next cycle new owner", h_rom_rdata, 8'h04);
        advance(); idle();

        // R3: sweep all sixteen nibbles while the coprocessor owns ROM
        for (int n = 0; n < 16; n++) begin
            h_rom_rd = 1; h_rom_addr = {17'h1ABCD, n[3:0]};
            settle();
            chk("R3 fill nibble", h_rom_rdata, exp_fill(n[3:0]));
            advance();
        end
        idle();

        // R10: coprocessor owns ROM while host owns RAM, both served at once
        h_ram_wr = 1; h_ram_addr = 17'h9; h_ram_wdata = 8'h3C; cycle(); idle();
        c_rom_rd = 1; c_rom_addr = 21'h1F00F; h_ram_rd = 1; h_ram_addr = 17'h9;
        settle();
        chk("R10 cop rom", c_rom_rdata, rom_fn(21'h1F00F));
        chk("R10 host ram", h_ram_rdata, 8'h3C);
        chk("R10 no wait", c_wait, 0);
        advance(); idle();

        // R5/R4: coprocessor owns RAM; host write dropped, host read sees open bus
        cfg_we = 1; cfg_wdata = 8'h08; cycle(); idle();
        h_ram_wr = 1; h_ram_addr = 17'h9; h_ram_wdata = 8'hA5;
        settle();
        chk("R5 no device write", ram_wr, 0);
        advance(); idle();
        h_ram_rd = 1; h_ram_addr = 17'h20;
        settle();
        chk("R4 open bus after write", h_ram_rdata, 8'hA5);
        advance(); idle();
        cfg_we = 1; cfg_wdata = 8'h00; cycle(); idle();
        h_ram_rd = 1; h_ram_addr = 17'h9;
        settle();
        chk("R5 stored byte kept", h_ram_rdata, 8'h3C);
        advance(); idle();

        // R9: coprocessor write while host owns RAM is discarded
        c_ram_wr = 1; c_ram_addr = 17'h9; c_ram_wdata = 8'h77;
        settle();
        chk("R9 wait on write", c_wait, 1);
        advance(); idle();
        h_ram_rd = 1; h_ram_addr = 17'h9;
        settle();
        chk("R9 byte unchanged", h_ram_rdata, 8'h3C);
        advance(); idle();

        // R7: waiting coprocessor resumes on the cycle after the grant
        c_rom_rd = 1; c_rom_addr = 21'h0_0ABC;
        cfg_we = 1; cfg_wdata = 8'h00; cycle();
        cfg_wdata = 8'h10;
        settle();
        chk("R7 still waiting", c_wait, 1);
        advance(); cfg_we = 0;
        settle();
        chk("R7 resumed", c_wait, 0);
        chk("R7 data", c_rom_rdata, rom_fn(21'h0_0ABC));
        advance(); idle();

        // Random traffic against the model.
        for (int k = 0; k < 4000; k++) begin
            int hop, cop;
            idle();
            cfg_we = ($urandom % 8) == 0;
            cfg_wdata = 8'($urandom);
            hop = $urandom % 4;
            h_rom_rd = (hop == 1); h_ram_rd = (hop == 2); h_ram_wr = (hop == 3);
            h_rom_addr = ROM_AW'($urandom);
            h_ram_addr = RAM_AW'($urandom % 256);
            h_ram_wdata = 8'($urandom);
            c_rom_rd = $urandom % 2;
            c_rom_addr = ROM_AW'($urandom);
            cop = $urandom % 3;
            c_ram_rd = (cop == 1); c_ram_wr = (cop == 2);
            c_ram_addr = RAM_AW'($urandom % 256);
            c_ram_wdata = 8'($urandom);
            cycle();
        end
        idle();
        finish_run();
    end
endmodule